// File: doc/BRIEF.md
# Keyed-Write Watchdog Timer

This peripheral watches over software by counting prescaler ticks in an 8-bit up-counter. Software refreshes the counter, usually by writing zero, before it rolls over. If the counter wraps from its maximum value to zero while the watchdog function is armed, an overflow flag is raised. If the reset-enable bit is also set, the block drives an internal reset output for a fixed number of clock cycles.

The reset control word is protected against stray writes. It only changes on a full 16-bit word write whose upper byte carries one of two key values. One key clears the overflow flag. The other loads the reset-enable and reset-select bits. All registers are read back one byte at a time at fixed offsets, and read data is registered. The synchronous reset input `rst` is the external reset. It takes precedence over everything else, including a watchdog overflow in the same cycle.

Top module: `wdk_top`

## Requirements
- R1: After `rst`, reads at offsets 0, 1, 2 and 3 all return 0x00, and `wdt_rst_o` is low.
- R2: While the enable bit (bit 5 of the control byte) is 1, the counter advances by one, modulo 256, on each cycle with `tick_i` high. While that bit is 0 it holds its value. A byte write at offset 1 loads the counter, and the write takes precedence over a tick in the same cycle.
- R3: When the counter wraps from 0xFF to 0x00 with both control bits 6 (watchdog mode) and 5 (enable) set, the overflow flag is set. The flag is bit 7 of the byte read at offset 3. A wrap with bit 6 clear leaves the flag unchanged.
- R4: A wrap that sets the flag while reset-enable (bit 6 of the offset-3 byte) is 1 drives `wdt_rst_o` high for exactly PULSE_LEN (512) consecutive cycles. It starts in the cycle after the wrap edge. With reset-enable at 0, no pulse occurs.
- R5: While `wdt_rst_o` is high, the counter and the control byte read 0 and ignore writes and ticks. The offset-3 byte keeps its contents.
- R6: A word write at offset 2 of 0xA500 clears the overflow flag and leaves bits 6 and 5 unchanged.
- R7: A word write at offset 2 with upper byte 0x5A copies bits 6 and 5 of the lower byte into reset-enable and reset-select (bits 6 and 5 of the offset-3 byte). The overflow flag is not changed.
- R8: Any of the following writes to offset 2 has no effect: a byte write, a word write whose upper byte is neither 0xA5 nor 0x5A, or a word write of 0xA5 with a non-zero lower byte.
- R9: If a wrap sets the flag in the same cycle as a flag-clear word write, the flag ends up set.
- R10: If `rst` is high in the cycle of a watchdog overflow, no pulse is produced and the flag reads 0.
- R11: A read returns, one cycle after `rd_addr` is applied, the following bytes. Offset 0 gives {0, mode, enable, 00000}. Offset 1 gives the counter. Offset 3 gives {flag, reset-enable, reset-select, 00000}. Offset 2 gives 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | External synchronous active-high reset |
| tick_i | input | 1 | Prescaler count enable pulse |
| wr_en_i | input | 1 | Write strobe |
| wr_word_i | input | 1 | 1 = 16-bit word write, 0 = byte write |
| wr_addr_i | input | 2 | Write offset |
| wr_data_i | input | 16 | Write data (byte writes use bits 7:0) |
| rd_addr_i | input | 2 | Read byte offset |
| rd_data_o | output | 8 | Registered read byte |
| wdt_rst_o | output | 1 | Internal reset pulse output |

## Verification
The counter is swept over every start value from 0x00 to 0xFF, with one to three ticks in timer-only mode. This separates correct modulo arithmetic from a missed increment or a wrap that wrongly raises the flag. Key patterns cover both valid keys, foreign upper bytes, the clear key with a non-zero lower byte, and byte-width attempts. These cases separate key decoding from width decoding. Overflow is driven in three contexts: reset-enable clear, reset-enable set, and coincident with `rst`. The pulse width is counted cycle by cycle, and writes and ticks are applied during the pulse to show they are held off.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  localparam int CNT_W     = 8;
  localparam int PULSE_LEN = 512;
  localparam int ADDR_W    = 2;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] OFS_CNT  = 2'd1;
  localparam logic [ADDR_W-1:0] OFS_RSW  = 2'd2;
  localparam logic [ADDR_W-1:0] OFS_RSR  = 2'd3;

  localparam logic [7:0] KEY_CLR  = 8'hA5;
  localparam logic [7:0] KEY_LOAD = 8'h5A;

  localparam int BIT_FLAG = 7;
  localparam int BIT_MODE = 6;
  localparam int BIT_EN   = 5;
  localparam int BIT_RSEN = 6;
  localparam int BIT_RSEL = 5;
endpackage

// File: rtl/wdk_timer.sv
module wdk_timer #(
  parameter int CNT_W = wdk_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold_i,
  input  logic             tick_i,
  input  logic             ctrl_we_i,
  input  logic [7:0]       ctrl_din_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_din_i,
  output logic             mode_o,
  output logic             en_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_evt_o
);
  import wdk_pkg::*;

  logic             mode_q, en_q;
  logic [CNT_W-1:0] cnt_q;
  logic             inc;

  assign inc       = en_q & tick_i & ~cnt_we_i & ~hold_i;
  assign ovf_evt_o = inc & mode_q & (cnt_q == {CNT_W{1'b1}});
  assign mode_o    = mode_q;
  assign en_o      = en_q;
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk) begin
    if (rst || hold_i) begin
      mode_q <= 1'b0;
      en_q   <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (ctrl_we_i) begin
        mode_q <= ctrl_din_i[BIT_MODE];
        en_q   <= ctrl_din_i[BIT_EN];
      end
      if (cnt_we_i)
        cnt_q <= cnt_din_i;
      else if (inc)
        cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_CNT_INC: assert property (@(posedge clk) disable iff (rst)
    (!hold_i && !cnt_we_i && en_q && tick_i) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R2
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!hold_i && !cnt_we_i && !en_q) |=> $stable(cnt_q)); // R2
  AST_HELD_IDLE: assert property (@(posedge clk) disable iff (rst)
    hold_i |=> (cnt_q == '0 && !mode_q && !en_q)); // R5
endmodule

// File: rtl/wdk_rstctl.sv
module wdk_rstctl (
  input  logic        clk,
  input  logic        rst,
  input  logic        word_we_i,
  input  logic [15:0] din_i,
  input  logic        ovf_evt_i,
  output logic        flag_o,
  output logic        rsen_o,
  output logic        rsel_o
);
  import wdk_pkg::*;

  logic flag_q, rsen_q, rsel_q;
  logic key_clr, key_load;

  assign key_clr  = word_we_i && din_i[15:8] == KEY_CLR && din_i[7:0] == 8'h00;
  assign key_load = word_we_i && din_i[15:8] == KEY_LOAD;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      rsen_q <= 1'b0;
      rsel_q <= 1'b0;
    end else begin
      if (ovf_evt_i)     flag_q <= 1'b1;
      else if (key_clr)  flag_q <= 1'b0;
      if (key_load) begin
        rsen_q <= din_i[BIT_RSEN];
        rsel_q <= din_i[BIT_RSEL];
      end
    end
  end

  assign flag_o = flag_q;
  assign rsen_o = rsen_q;
  assign rsel_o = rsel_q;

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    ovf_evt_i |=> flag_q); // R3
  AST_BAD_KEY: assert property (@(posedge clk) disable iff (rst)
    (!ovf_evt_i && !key_clr && !key_load) |=> ($stable(flag_q) && $stable(rsen_q) && $stable(rsel_q))); // R8
  AST_LOAD_KEEPS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (key_load && !ovf_evt_i) |=> $stable(flag_q)); // R7
  AST_RST_FLAG: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !flag_q); // R10
endmodule

// File: rtl/wdk_pulse.sv
module wdk_pulse #(
  parameter int PULSE_LEN = wdk_pkg::PULSE_LEN
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic active_o
);
  localparam int REM_W = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;

  logic             active_q;
  logic [REM_W-1:0] rem_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      rem_q    <= '0;
    end else if (active_q) begin
      if (rem_q == '0) active_q <= 1'b0;
      else             rem_q    <= rem_q - 1'b1;
    end else if (start_i) begin
      active_q <= 1'b1;
      rem_q    <= REM_W'(PULSE_LEN - 1);
    end
  end

  assign active_o = active_q;

  AST_PULSE_START: assert property (@(posedge clk) disable iff (rst)
    (start_i && !active_q) |=> active_q); // R4
  AST_PULSE_RST: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !active_q); // R10
endmodule

// File: rtl/wdk_top.sv
module wdk_top #(
  parameter int CNT_W     = wdk_pkg::CNT_W,
  parameter int PULSE_LEN = wdk_pkg::PULSE_LEN,
  parameter int ADDR_W    = wdk_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic              wr_word_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [15:0]       wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              wdt_rst_o
);
  import wdk_pkg::*;

  logic             ctrl_we, cnt_we, rsw_we;
  logic             mode, en, ovf_evt, hold;
  logic [CNT_W-1:0] cnt;
  logic             flag, rsen, rsel;
  logic [7:0]       rd_mux;

  assign ctrl_we = wr_en_i && !wr_word_i && wr_addr_i == OFS_CTRL;
  assign cnt_we  = wr_en_i && !wr_word_i && wr_addr_i == OFS_CNT;
  assign rsw_we  = wr_en_i &&  wr_word_i && wr_addr_i == OFS_RSW;

  wdk_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .hold_i(hold), .tick_i(tick_i),
    .ctrl_we_i(ctrl_we), .ctrl_din_i(wr_data_i[7:0]),
    .cnt_we_i(cnt_we), .cnt_din_i(wr_data_i[CNT_W-1:0]),
    .mode_o(mode), .en_o(en), .cnt_o(cnt), .ovf_evt_o(ovf_evt)
  );

  wdk_rstctl u_rstctl (
    .clk(clk), .rst(rst), .word_we_i(rsw_we), .din_i(wr_data_i),
    .ovf_evt_i(ovf_evt), .flag_o(flag), .rsen_o(rsen), .rsel_o(rsel)
  );

  wdk_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst(rst), .start_i(ovf_evt & rsen), .active_o(hold)
  );

  assign wdt_rst_o = hold;

  always_comb begin
    rd_mux = 8'h00;
    case (rd_addr_i)
      OFS_CTRL: begin
        rd_mux[BIT_MODE] = mode;
        rd_mux[BIT_EN]   = en;
      end
      OFS_CNT: rd_mux = 8'(cnt);
      OFS_RSR: begin
        rd_mux[BIT_FLAG] = flag;
        rd_mux[BIT_RSEN] = rsen;
        rd_mux[BIT_RSEL] = rsel;
      end
      default: rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data_o <= 8'h00;
    else     rd_data_o <= rd_mux;
  end

  AST_NO_PULSE_DISARMED: assert property (@(posedge clk) disable iff (rst)
    (!rsen && !hold) |=> !hold); // R4
endmodule

// File: tb/wdk_top_tb.sv
module wdk_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic        wr_word_i = 1'b0;
  logic [1:0]  wr_addr_i = 2'd0;
  logic [15:0] wr_data_i = 16'h0;
  logic [1:0]  rd_addr_i = 2'd0;
  logic [7:0]  rd_data_o;
  logic        wdt_rst_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wdk_top u_dut (
    .clk(clk), .rst(rst), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_word_i(wr_word_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .wdt_rst_o(wdt_rst_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [1:0] a, input logic [7:0] d);
    wr_en_i = 1'b1; wr_word_i = 1'b0; wr_addr_i = a; wr_data_i = {8'h00, d};
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic wr_word(input logic [1:0] a, input logic [15:0] d);
    wr_en_i = 1'b1; wr_word_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0; wr_word_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    rd_addr_i = a;
    @(negedge clk);
    v = int'(rd_data_o);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1 (run did not finish)");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int v;
    int highs;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 wdt_rst_o", int'(wdt_rst_o), 0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk("R1 read", v, 0);
    end

    // R11: read layout
    wr_byte(2'd0, 8'h7F);
    rd(2'd0, v); chk("R11 ctrl read", v, 8'h60);
    rd(2'd2, v); chk("R11 offset2 read", v, 0);
    wr_byte(2'd1, 8'h9C);
    rd(2'd1, v); chk("R11 counter read", v, 8'h9C);

    // R2: sweep all start values in timer-only mode (enable, no watchdog mode)
    wr_byte(2'd0, 8'h20);
    for (int s = 0; s < 256; s++) begin
      wr_byte(2'd1, 8'(s));
      ticks((s % 3) + 1);
      rd(2'd1, v);
      chk("R2 count", v, (s + (s % 3) + 1) % 256);
    end
    rd(2'd3, v); chk("R3 no flag without mode", v, 0);

    // R2: hold when disabled
    wr_byte(2'd0, 8'h00);
    wr_byte(2'd1, 8'h10);
    ticks(3);
    rd(2'd1, v); chk("R2 hold", v, 8'h10);

    // R2: write beats tick
    wr_byte(2'd0, 8'h20);
    tick_i = 1'b1;
    wr_byte(2'd1, 8'h40);
    tick_i = 1'b0;
    rd(2'd1, v); chk("R2 write wins", v, 8'h40);

    // R7: load reset-select only
    wr_word(2'd2, 16'h5A20);
    rd(2'd3, v); chk("R7 load", v, 8'h20);

    // R9 / R3: overflow with simultaneous clear
    wr_byte(2'd0, 8'h60);
    wr_byte(2'd1, 8'hFF);
    tick_i = 1'b1;
    wr_word(2'd2, 16'hA500);
    tick_i = 1'b0;
    rd(2'd3, v); chk("R9 set beats clear", v, 8'hA0);
    chk("R4 no pulse when disarmed", int'(wdt_rst_o), 0);
    rd(2'd1, v); chk("R3 wrapped counter", v, 0);

    // R8: ignored writes
    wr_byte(2'd2, 8'h00);
    wr_word_i = 1'b0;
    wr_en_i = 1'b1; wr_addr_i = 2'd2; wr_data_i = 16'hA500;
    @(negedge clk); wr_en_i = 1'b0;
    rd(2'd3, v); chk("R8 byte write", v, 8'hA0);
    wr_word(2'd2, 16'h1260);
    rd(2'd3, v); chk("R8 foreign key", v, 8'hA0);
    wr_word(2'd2, 16'hA501);
    rd(2'd3, v); chk("R8 clear key nonzero low", v, 8'hA0);

    // R7: load keeps flag
    wr_word(2'd2, 16'h5A40);
    rd(2'd3, v); chk("R7 load keeps flag", v, 8'hC0);

    // R6: clear keeps enable bits
    wr_word(2'd2, 16'hA500);
    rd(2'd3, v); chk("R6 clear", v, 8'h40);

    // R4 / R5: armed overflow
    wr_byte(2'd0, 8'h60);
    wr_byte(2'd1, 8'hFF);
    ticks(1);
    chk("R4 pulse start", int'(wdt_rst_o), 1);
    highs = 0;
    tick_i = 1'b1;
    wr_en_i = 1'b1; wr_word_i = 1'b0; wr_addr_i = 2'd1; wr_data_i = 16'h0033;
    highs += int'(wdt_rst_o); @(negedge clk);
    wr_addr_i = 2'd0; wr_data_i = 16'h0060;
    highs += int'(wdt_rst_o); @(negedge clk);
    wr_en_i = 1'b0; rd_addr_i = 2'd1;
    highs += int'(wdt_rst_o); @(negedge clk);
    chk("R5 counter held", int'(rd_data_o), 0);
    rd_addr_i = 2'd0;
    highs += int'(wdt_rst_o); @(negedge clk);
    chk("R5 ctrl held", int'(rd_data_o), 0);
    tick_i = 1'b0;
    while (wdt_rst_o && highs < 2000) begin
      highs++;
      @(negedge clk);
    end
    chk("R4 pulse length", highs, 512);
    rd(2'd0, v); chk("R5 ctrl after pulse", v, 0);
    rd(2'd1, v); chk("R5 counter after pulse", v, 0);
    rd(2'd3, v); chk("R5 reset reg kept", v, 8'hC0);

    // R10: external reset coincides with overflow
    wr_word(2'd2, 16'hA500);
    wr_byte(2'd0, 8'h60);
    wr_byte(2'd1, 8'hFF);
    tick_i = 1'b1; rst = 1'b1;
    @(negedge clk);
    tick_i = 1'b0; rst = 1'b0;
    highs = 0;
    for (int i = 0; i < 10; i++) begin
      highs += int'(wdt_rst_o);
      @(negedge clk);
    end
    chk("R10 no pulse", highs, 0);
    rd(2'd3, v); chk("R10 flag clear", v, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule